// File: doc/BRIEF.md
# I2C SCL Sub-Phase Timing Generator

This block produces the SCL waveform of an I2C master and the single-cycle strobes that a bit-level engine uses to move SDA. It runs from a fast input clock. Each half of a bit period is cut into eight equal sub-phases. The low half's sub-phase length comes from a low divisor and the high half's from a high divisor. Three 2-bit tuning fields control three things: where in the low half SDA may change, how many high periods the START setup and hold last, and how many high periods the STOP setup lasts.

The bit engine sends one command at a time over a valid/ready channel. A command is a data bit slot, a START or a STOP. The engine may hold `cmd_valid` high for as long as it likes. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. While a command runs, `cmd_ready` stays low, which is the back-pressure. Between commands the generator either rests with SCL high (bus idle, after reset or a STOP) or parks with SCL low (after a bit or a START), and it waits there for the next command. The divisor and tuning inputs are plain configuration pins, and they are sampled only when a command is taken.

Top module: `scl_phase_gen`

## Requirements
- R1: While reset is held and right after it, `scl_o` is 1, `cmd_ready` is 1 and every strobe is 0.
- R2: A command is taken on a clock edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is high only while idle or parked. `cmd_op` codes are: 0 = bit slot, 1 = START, 2 = STOP, 3 = bit slot.
- R3: `div_cfg[31:16]` is the high divisor divh and `div_cfg[15:0]` is the low divisor divl. In a bit slot, SCL is low for 8*(divl+1) clocks, starting with the cycle after the command is taken. SCL is then high for 8*(divh+1) clocks, and then the block parks with SCL low.
- R4: Let s = `tune_sda`+1. In every low half, `sda_upd_stb` pulses once, at low-half cycle s*(divl+1)-1 (cycles counted from 0). This leaves (8-s)*(divl+1)+1 clocks of data setup before SCL rises.
- R5: `scl_rise_stb` pulses in the first high cycle that follows a low half. In a bit slot, `sda_smp_stb` pulses 4*(divh+1) cycles after that rise, which is the first cycle of the fifth high sub-phase.
- R6: Let m = `tune_sta`+1. A START taken while idle keeps SCL high. `start_stb` pulses 8*(divh+1)*m cycles after the command is taken. SCL then stays high for 8*(divh+1)*m-1 more cycles, and the block parks low.
- R7: A START taken while parked first runs a low half, with its `sda_upd_stb` and then `scl_rise_stb`. It then follows the R6 timing, counted from the rise.
- R8: Let k = `tune_sto`+1. A STOP taken while parked runs a low half and a rise, then holds SCL high for 8*(divh+1)*k cycles. `stop_stb` pulses in the last of those cycles, and the block returns to idle.
- R9: A STOP taken while idle has no effect. SCL stays high, `cmd_ready` stays high and no strobe fires.
- R10: Divisors and tuning fields are captured in the cycle a command is taken. Changing them while the command runs does not alter its timing.
- R11: Divisors of zero still clock, giving 8 input clocks per half.
- R12: Each strobe lasts one cycle, and no two strobes fire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered by the bit engine |
| cmd_ready | output | 1 | Generator can take a command (idle or parked) |
| cmd_op | input | 2 | 0 bit slot, 1 START, 2 STOP, 3 bit slot |
| div_cfg | input | 32 | [31:16] high divisor, [15:0] low divisor, each one less than the sub-phase length |
| tune_sda | input | 2 | SDA change sub-phase in the low half, minus one |
| tune_sta | input | 2 | START setup/hold multiplier minus one |
| tune_sto | input | 2 | STOP setup multiplier minus one |
| scl_o | output | 1 | SCL level (1 = released) |
| sda_upd_stb | output | 1 | SDA may change now |
| scl_rise_stb | output | 1 | SCL just rose |
| sda_smp_stb | output | 1 | Capture SDA now |
| start_stb | output | 1 | Pull SDA low for START now |
| stop_stb | output | 1 | Release SDA for STOP now |

## Verification
Two events can fall in the same clock cycle: the end of one command and the taking of the next, and with it a change of divisor or tuning settings. The bench provokes this by presenting each new command, often with new settings, in the very cycle in which `cmd_ready` returns high. It then checks that the new command's whole timing follows the new settings. A separate scenario changes the settings a few cycles after a command is taken and judges the result by the position of every strobe and by the count of SCL-low cycles, which must still match the old settings.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
  localparam int SUBPH_N = 8;

  typedef enum logic [1:0] {
    OP_BIT   = 2'd0,
    OP_START = 2'd1,
    OP_STOP  = 2'd2,
    OP_BIT2  = 2'd3
  } sg_op_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,  // SCL high, bus free
    PH_PARK = 3'd1,  // SCL low, waiting for next command
    PH_LOW  = 3'd2,  // low half of a slot
    PH_HIGH = 3'd3,  // high half of a bit slot
    PH_SSU  = 3'd4,  // START setup, SCL high
    PH_SHD  = 3'd5,  // START hold, SCL high
    PH_PSU  = 3'd6   // STOP setup, SCL high
  } sg_phase_e;
endpackage

// File: rtl/sg_subtick.sv
module sg_subtick #(
  parameter int DIV_W = 16,
  parameter int SUB_N = 8,
  parameter int REP_W = 2,
  localparam int SUB_W = $clog2(SUB_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] lim,
  input  logic [REP_W-1:0] rep_lim,
  output logic [DIV_W-1:0] cnt,
  output logic [SUB_W-1:0] sub,
  output logic             tick_end,
  output logic             phase_end,
  output logic             first
);
  logic [REP_W-1:0] rep;
  logic             sub_last;

  assign tick_end  = (cnt == lim);
  assign sub_last  = (sub == SUB_W'(SUB_N - 1));
  assign phase_end = tick_end && sub_last && (rep == rep_lim);
  assign first     = (cnt == '0) && (sub == '0) && (rep == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sub <= '0;
      rep <= '0;
    end else if (restart) begin
      cnt <= '0;
      sub <= '0;
      rep <= '0;
    end else if (tick_end) begin
      cnt <= '0;
      if (sub_last) begin
        sub <= '0;
        rep <= (rep == rep_lim) ? '0 : rep + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sg_phase_ctl.sv
module sg_phase_ctl
  import sclgen_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int TUNE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [2*DIV_W-1:0] div_cfg,
  input  logic [TUNE_W-1:0]  tune_sda,
  input  logic [TUNE_W-1:0]  tune_sta,
  input  logic [TUNE_W-1:0]  tune_sto,
  input  logic               phase_end,
  output sg_phase_e          phase,
  output logic               cmd_ready,
  output logic               restart,
  output logic [DIV_W-1:0]   lim,
  output logic [TUNE_W-1:0]  rep_lim,
  output logic [TUNE_W-1:0]  sda_sel,
  output logic               rise_q
);
  sg_phase_e        entry_ph, after_ph;
  sg_op_e           op_in, op_q;
  logic [DIV_W-1:0] divl_q, divh_q;
  logic [TUNE_W-1:0] sta_q, sto_q;
  logic             busy, accept, advance;

  assign op_in     = sg_op_e'(cmd_op);
  assign busy      = !(phase == PH_IDLE || phase == PH_PARK);
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && !busy;
  assign advance   = busy && phase_end;
  assign restart   = accept || advance;

  always_comb begin
    case (op_in)
      OP_START: entry_ph = (phase == PH_IDLE) ? PH_SSU : PH_LOW;
      OP_STOP:  entry_ph = (phase == PH_IDLE) ? PH_IDLE : PH_LOW;
      default:  entry_ph = PH_LOW;
    endcase
  end

  always_comb begin
    case (phase)
      PH_LOW:  after_ph = (op_q == OP_START) ? PH_SSU :
                          (op_q == OP_STOP)  ? PH_PSU : PH_HIGH;
      PH_HIGH: after_ph = PH_PARK;
      PH_SSU:  after_ph = PH_SHD;
      PH_SHD:  after_ph = PH_PARK;
      PH_PSU:  after_ph = PH_IDLE;
      default: after_ph = phase;
    endcase
  end

  always_comb begin
    lim = (phase == PH_LOW) ? divl_q : divh_q;
    case (phase)
      PH_SSU, PH_SHD: rep_lim = sta_q;
      PH_PSU:         rep_lim = sto_q;
      default:        rep_lim = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      op_q    <= OP_BIT;
      divl_q  <= '0;
      divh_q  <= '0;
      sda_sel <= '0;
      sta_q   <= '0;
      sto_q   <= '0;
      rise_q  <= 1'b0;
    end else begin
      rise_q <= (phase == PH_LOW) && phase_end;
      if (accept) begin
        phase   <= entry_ph;
        op_q    <= op_in;
        divl_q  <= div_cfg[DIV_W-1:0];
        divh_q  <= div_cfg[2*DIV_W-1:DIV_W];
        sda_sel <= tune_sda;
        sta_q   <= tune_sta;
        sto_q   <= tune_sto;
      end else if (advance) begin
        phase <= after_ph;
      end
    end
  end
endmodule

// File: rtl/sg_strobe_dec.sv
module sg_strobe_dec
  import sclgen_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int SUB_N  = 8,
  parameter int TUNE_W = 2,
  localparam int SUB_W = $clog2(SUB_N)
) (
  input  sg_phase_e         phase,
  input  logic [DIV_W-1:0]  cnt,
  input  logic [SUB_W-1:0]  sub,
  input  logic              tick_end,
  input  logic              first,
  input  logic              phase_end,
  input  logic [TUNE_W-1:0] sda_sel,
  output logic              sda_upd_stb,
  output logic              sda_smp_stb,
  output logic              start_stb,
  output logic              stop_stb
);
  assign sda_upd_stb = (phase == PH_LOW) && (sub == SUB_W'(sda_sel)) && tick_end;
  assign sda_smp_stb = (phase == PH_HIGH) && (sub == SUB_W'(SUB_N / 2)) && (cnt == '0);
  assign start_stb   = (phase == PH_SHD) && first;
  assign stop_stb    = (phase == PH_PSU) && phase_end;
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import sclgen_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int TUNE_W = 2,
  parameter int SUB_N  = SUBPH_N,
  localparam int SUB_W = $clog2(SUB_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [2*DIV_W-1:0] div_cfg,
  input  logic [TUNE_W-1:0]  tune_sda,
  input  logic [TUNE_W-1:0]  tune_sta,
  input  logic [TUNE_W-1:0]  tune_sto,
  output logic               scl_o,
  output logic               sda_upd_stb,
  output logic               scl_rise_stb,
  output logic               sda_smp_stb,
  output logic               start_stb,
  output logic               stop_stb
);
  sg_phase_e         phase;
  logic              restart, tick_end, phase_end, first, rise_q;
  logic [DIV_W-1:0]  lim, cnt;
  logic [TUNE_W-1:0] rep_lim, sda_sel;
  logic [SUB_W-1:0]  sub;

  sg_phase_ctl #(.DIV_W(DIV_W), .TUNE_W(TUNE_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .div_cfg(div_cfg), .tune_sda(tune_sda), .tune_sta(tune_sta),
    .tune_sto(tune_sto), .phase_end(phase_end), .phase(phase),
    .cmd_ready(cmd_ready), .restart(restart), .lim(lim),
    .rep_lim(rep_lim), .sda_sel(sda_sel), .rise_q(rise_q)
  );

  sg_subtick #(.DIV_W(DIV_W), .SUB_N(SUB_N), .REP_W(TUNE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .lim(lim),
    .rep_lim(rep_lim), .cnt(cnt), .sub(sub), .tick_end(tick_end),
    .phase_end(phase_end), .first(first)
  );

  sg_strobe_dec #(.DIV_W(DIV_W), .SUB_N(SUB_N), .TUNE_W(TUNE_W)) u_dec (
    .phase(phase), .cnt(cnt), .sub(sub), .tick_end(tick_end),
    .first(first), .phase_end(phase_end), .sda_sel(sda_sel),
    .sda_upd_stb(sda_upd_stb), .sda_smp_stb(sda_smp_stb),
    .start_stb(start_stb), .stop_stb(stop_stb)
  );

  assign scl_o        = !(phase == PH_LOW || phase == PH_PARK);
  assign scl_rise_stb = rise_q;
endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       scl_o,
  input logic       sda_upd_stb,
  input logic       scl_rise_stb,
  input logic       sda_smp_stb,
  input logic       start_stb,
  input logic       stop_stb
);
  AST_TAKEN_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_op != 2'd2 || !scl_o)) |=> !cmd_ready); // R2
  AST_UPD_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sda_upd_stb |-> (!scl_o && !cmd_ready)); // R4
  AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sda_upd_stb |=> !sda_upd_stb); // R4
  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_stb |-> (scl_o && !$past(scl_o))); // R5
  AST_SMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sda_smp_stb |-> scl_o); // R5
  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |-> (scl_o && !cmd_ready)); // R6
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> (cmd_ready && scl_o)); // R8
  AST_IDLE_STOP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && scl_o && cmd_op == 2'd2) |=> (cmd_ready && scl_o)); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sda_upd_stb, scl_rise_stb, sda_smp_stb, start_stb, stop_stb})); // R12
endmodule

bind scl_phase_gen scl_phase_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .scl_o(scl_o), .sda_upd_stb(sda_upd_stb),
  .scl_rise_stb(scl_rise_stb), .sda_smp_stb(sda_smp_stb),
  .start_stb(start_stb), .stop_stb(stop_stb)
);

// File: tb/scl_phase_gen_tb.sv
module scl_phase_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic [31:0] div_cfg;
  logic [1:0]  tune_sda, tune_sta, tune_sto;
  logic        scl_o, sda_upd_stb, scl_rise_stb, sda_smp_stb, start_stb, stop_stb;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scl_phase_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .div_cfg(div_cfg), .tune_sda(tune_sda),
    .tune_sta(tune_sta), .tune_sto(tune_sto), .scl_o(scl_o),
    .sda_upd_stb(sda_upd_stb), .scl_rise_stb(scl_rise_stb),
    .sda_smp_stb(sda_smp_stb), .start_stb(start_stb), .stop_stb(stop_stb)
  );

  task automatic check(string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int cnt_exp(int t);
    return (t >= 0) ? 1 : 0;
  endfunction

  // Issues one command at a negedge with cmd_ready high and follows it
  // until cmd_ready returns; times are cycles after the accepting edge.
  task automatic run_cmd(string tag, logic [1:0] op, bit mid_chg,
                         int e_upd, int e_rise, int e_smp, int e_start,
                         int e_stop, int e_end, int e_low, int e_scl);
    int t_upd = -1, t_rise = -1, t_smp = -1, t_start = -1, t_stop = -1;
    int t_end = -1, n_low = 0, n_stb = 0;
    check({tag, " ready before issue (R2)"}, int'(cmd_ready), 1);
    cmd_op    = op;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int t = 0; t < 4000; t++) begin
      if (cmd_ready) begin
        t_end = t;
        break;
      end
      if (mid_chg && t == 5) begin
        div_cfg  = 32'h0000_0000;
        tune_sda = 2'd3;
        tune_sta = 2'd3;
        tune_sto = 2'd3;
      end
      if (!scl_o) n_low++;
      n_stb += int'(sda_upd_stb) + int'(scl_rise_stb) + int'(sda_smp_stb)
             + int'(start_stb) + int'(stop_stb);
      if (sda_upd_stb  && t_upd   < 0) t_upd   = t;
      if (scl_rise_stb && t_rise  < 0) t_rise  = t;
      if (sda_smp_stb  && t_smp   < 0) t_smp   = t;
      if (start_stb    && t_start < 0) t_start = t;
      if (stop_stb     && t_stop  < 0) t_stop  = t;
      @(negedge clk);
    end
    check({tag, " ready return"}, t_end, e_end);
    check({tag, " scl low cycles"}, n_low, e_low);
    check({tag, " upd time"}, t_upd, e_upd);
    check({tag, " rise time"}, t_rise, e_rise);
    check({tag, " sample time"}, t_smp, e_smp);
    check({tag, " start time"}, t_start, e_start);
    check({tag, " stop time"}, t_stop, e_stop);
    check({tag, " strobe total (R12)"}, n_stb,
          cnt_exp(e_upd) + cnt_exp(e_rise) + cnt_exp(e_smp)
          + cnt_exp(e_start) + cnt_exp(e_stop));
    check({tag, " scl after command"}, int'(scl_o), e_scl);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_op = 2'd0;
    div_cfg = 32'h0001_0002;
    tune_sda = 2'd0;
    tune_sta = 2'd0;
    tune_sto = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 scl in reset", int'(scl_o), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 scl after reset", int'(scl_o), 1);
    check("R1 ready after reset", int'(cmd_ready), 1);
    check("R1 strobes after reset",
          int'({sda_upd_stb, scl_rise_stb, sda_smp_stb, start_stb, stop_stb}), 0);
  endtask

  task automatic t_stop_idle;  // no effect while the bus is idle
    run_cmd("R9 stop idle", 2'd2, 1'b0, -1, -1, -1, -1, -1, 0, 0, 1);
  endtask

  task automatic t_bit_idle;  // divl=2 -> L=3, divh=1 -> H=2, s=1
    div_cfg = 32'h0001_0002; tune_sda = 2'd0;
    run_cmd("R3 R4 R5 bit from idle", 2'd0, 1'b0, 2, 24, 32, -1, -1, 40, 24, 0);
  endtask

  task automatic t_bit_late_upd;  // s=4, op code 3 also a bit slot
    div_cfg = 32'h0001_0002; tune_sda = 2'd3;
    run_cmd("R2 R4 bit code3 s4", 2'd3, 1'b0, 11, 24, 32, -1, -1, 40, 24, 0);
  endtask

  task automatic t_bit_new_div;  // L=4, H=3, s=2, settings change at the take cycle
    div_cfg = 32'h0002_0003; tune_sda = 2'd1;
    run_cmd("R3 R4 R5 bit new div", 2'd0, 1'b0, 7, 32, 44, -1, -1, 56, 32, 0);
  endtask

  task automatic t_restart;  // L=3, H=2, m=2
    div_cfg = 32'h0001_0002; tune_sda = 2'd0; tune_sta = 2'd1;
    run_cmd("R7 repeated start", 2'd1, 1'b0, 2, 24, -1, 56, -1, 88, 24, 0);
  endtask

  task automatic t_stop_park;  // L=3, H=2, k=3
    div_cfg = 32'h0001_0002; tune_sda = 2'd0; tune_sto = 2'd2;
    run_cmd("R8 stop from park", 2'd2, 1'b0, 2, 24, -1, -1, 71, 72, 24, 1);
  endtask

  task automatic t_start_idle;  // H=2, m=1
    div_cfg = 32'h0001_0002; tune_sta = 2'd0;
    run_cmd("R6 start from idle", 2'd1, 1'b0, -1, -1, -1, 16, -1, 32, 0, 0);
  endtask

  task automatic t_start_idle_m4;  // H=1, m=4
    div_cfg = 32'h0000_0001; tune_sta = 2'd3;
    run_cmd("R6 start idle m4", 2'd1, 1'b0, -1, -1, -1, 32, -1, 64, 0, 0);
  endtask

  task automatic t_zero_div;  // L=H=1, s=3
    div_cfg = 32'h0000_0000; tune_sda = 2'd2;
    run_cmd("R11 zero divisors", 2'd0, 1'b0, 2, 8, 12, -1, -1, 16, 8, 0);
  endtask

  task automatic t_mid_change;  // settings change at t=5 must not matter
    div_cfg = 32'h0001_0002; tune_sda = 2'd1;
    run_cmd("R10 mid-command change", 2'd0, 1'b1, 5, 24, 32, -1, -1, 40, 24, 0);
  endtask

  task automatic t_final_stop;  // settings now zero: L=H=1, s=4, k=4
    run_cmd("R8 R10 stop after change", 2'd2, 1'b0, 3, 8, -1, -1, 39, 40, 8, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_stop_idle();
    t_bit_idle();
    t_bit_late_upd();
    t_bit_new_div();
    t_restart();
    t_stop_park();
    t_start_idle();
    t_zero_div();
    t_mid_change();
    t_final_stop();
    t_start_idle_m4();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule